// File: doc/BRIEF.md
# Eight-Channel Input Glitch Filter

This block cleans up eight slow general-purpose input pins before they reach edge-detection or state logic. Every raw pin is first brought into the system clock domain by a two-stage synchronizer. A channel whose filter is switched on compares each sample of its synchronized pin against the level it currently presents. The sample is taken on cycles where a shared sampling strobe is high. The channel adopts a new level only after three consecutive samples agree on it, so shorter excursions are dropped as noise. A channel whose filter is off forwards the synchronized pin unchanged.

Software selects filtered channels through one byte-wide read/write enable register at bus address 0xDF. While the stop-mode input is high, every channel is forced into pass-through. When stop mode is released, the register contents apply again without being rewritten. Whenever a channel enters filtering, its stored level is taken from the pin, so the change of mode itself never creates an edge. The prescaler that produces the strobe and any edge-interrupt logic lie outside this block.

Top module: `pin_debounce_filter`

## Requirements
- R1: After reset the enable register reads 0x00 at address 0xDF, and every output follows its synchronized pin.
- R2: A write with `reg_addr` = 0xDF loads `reg_wdata` into the enable register on the clock edge that samples `reg_wr`. A write to any other address leaves it unchanged. A read at 0xDF returns the register, and a read at any other address returns 0x00.
- R3: Enable bit i (1 = filter, 0 = pass) controls channel i alone. Channels 0 to 3 serve pins 0 to 3 of the first port, and channels 4 to 7 serve pins 0 to 3 of the second port. A pulse on a disabled channel passes even while every other channel is filtering.
- R4: A disabled channel's output equals its raw pin delayed by exactly two clock edges: a raw change made after edge E0 shows at the output after edge E2.
- R5: An enabled channel changes its output only on a strobe edge where the same new level has been sampled three times in a row. With the strobe high on every cycle, a raw change made after edge E0 shows at the output after edge E5.
- R6: With the strobe high on every cycle, an enabled channel suppresses a raw pulse of 1 or 2 cycles completely. It reproduces a pulse of L >= 3 cycles as an output pulse of exactly L cycles.
- R7: The agreement count advances only on strobe cycles. With one strobe every 4 cycles, raw pulses of 7 or 8 cycles are suppressed, and pulses of 12 or 16 cycles appear with their full length.
- R8: While `stop_mode` is high, all outputs follow the synchronized pins, whatever the enable register holds. A one-cycle pulse then passes two edges after it is applied.
- R9: After `stop_mode` falls, the channels selected by the register filter again, and a one-cycle pulse is suppressed once more, with no register write needed.
- R10: Enabling a channel, or releasing stop mode, produces no output edge while the pin is steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 8 | Register bus address |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| pins_raw | input | 8 | Asynchronous raw pin levels |
| sample_stb | input | 1 | Sampling strobe, one clock cycle wide per sample |
| stop_mode | input | 1 | Low-power stop indication; forces pass-through |
| pins_filt | output | 8 | Filtered pin levels |

## Verification
The assertions assume that `stop_mode`, `sample_stb` and the register bus are synchronous to `clk` and settle between edges. Only `pins_raw` may change at any time. The bench drives every input shortly after a rising edge and samples outputs on falling edges. It makes its strobe with nonblocking assignments, so each input is stable through the edge that captures it. The filter and stop-mode checks compare outputs only against the synchronizer output. This keeps them independent of when a raw pin change is actually captured.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  // Number of consecutive agreeing samples needed to accept a new level.
  parameter int unsigned DBF_DEF_AGREE = 3;

  // Operating mode of a single channel.
  typedef enum logic {
    CH_PASS   = 1'b0,
    CH_FILTER = 1'b1
  } ch_mode_e;

endpackage

// File: rtl/dbf_rst_sync.sv
module dbf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;

endmodule

// File: rtl/dbf_channel.sv
module dbf_channel
  import dbf_pkg::*;
#(
  parameter int unsigned AGREE = DBF_DEF_AGREE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_on,
  input  logic sample_en,
  input  logic din,
  output logic dout
);

  localparam int unsigned CW = $clog2(AGREE + 1);
  localparam logic [CW-1:0] LAST = CW'(AGREE - 1);

  ch_mode_e        mode;
  logic            lvl_q, lvl_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  assign mode = filt_on ? CH_FILTER : CH_PASS;

  // Next-state: in pass mode the stored level tracks the pin so that entry
  // into filter mode starts from the present level.
  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (mode == CH_PASS) begin
      lvl_d = din;
      cnt_d = '0;
    end else if (sample_en) begin
      if (din != lvl_q) begin
        if (cnt_q == LAST) begin
          lvl_d = din;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign dout = (mode == CH_FILTER) ? lvl_q : din;

endmodule

// File: rtl/pin_debounce_filter.sv
module pin_debounce_filter
  import dbf_pkg::*;
#(
  parameter int unsigned      CHANNELS = 8,
  parameter int unsigned      AGREE    = DBF_DEF_AGREE,
  parameter int unsigned      ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hDF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [CHANNELS-1:0] reg_wdata,
  output logic [CHANNELS-1:0] reg_rdata,
  input  logic [CHANNELS-1:0] pins_raw,
  input  logic                sample_stb,
  input  logic                stop_mode,
  output logic [CHANNELS-1:0] pins_filt
);

  logic                rst_int_n;
  logic [CHANNELS-1:0] pins_sync;
  logic [CHANNELS-1:0] en_q, en_d;
  logic                reg_hit;
  logic                wr_en;

  dbf_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dbf_sync #(.WIDTH(CHANNELS)) u_pin_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (pins_raw),
    .sync_out (pins_sync)
  );

  // Enable register
  assign reg_hit = (reg_addr == REG_ADDR);
  assign wr_en   = reg_wr & reg_hit;

  always_comb begin
    en_d = en_q;
    if (wr_en) begin
      en_d = reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end

  assign reg_rdata = reg_hit ? en_q : '0;

  // Per-channel filters
  for (genvar gi = 0; gi < CHANNELS; gi++) begin : g_ch
    dbf_channel #(.AGREE(AGREE)) u_ch (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .filt_on   (en_q[gi] & ~stop_mode),
      .sample_en (sample_stb),
      .din       (pins_sync[gi]),
      .dout      (pins_filt[gi])
    );
  end

endmodule

// File: rtl/dbf_checker.sv
module dbf_checker #(
  parameter int unsigned       CHANNELS = 8,
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hDF
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_wr,
  input logic [CHANNELS-1:0] reg_wdata,
  input logic [CHANNELS-1:0] en_q,
  input logic                sample_stb,
  input logic                stop_mode,
  input logic [CHANNELS-1:0] pins_sync,
  input logic [CHANNELS-1:0] pins_filt
);

  logic [CHANNELS-1:0] act;
  assign act = en_q & {CHANNELS{~stop_mode}};

  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_ADDR) |=> (en_q == $past(reg_wdata)));

  assert_reg_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == REG_ADDR) |=> $stable(en_q));

  assert_disabled_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~en_q) & (pins_filt ^ pins_sync)) == '0);

  assert_stop_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |-> (pins_filt == pins_sync));

  assert_strobe_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> (((pins_filt ^ $past(pins_filt)) & act & $past(act)) == '0));

  assert_new_level_from_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((((pins_filt ^ $past(pins_filt)) & act & $past(act))
                & (pins_filt ^ $past(pins_sync))) == '0));

endmodule

bind pin_debounce_filter dbf_checker #(
  .CHANNELS (CHANNELS),
  .ADDR_W   (ADDR_W),
  .REG_ADDR (REG_ADDR)
) u_dbf_checker (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .en_q       (en_q),
  .sample_stb (sample_stb),
  .stop_mode  (stop_mode),
  .pins_sync  (pins_sync),
  .pins_filt  (pins_filt)
);

// File: tb/test_pin_debounce_filter.sv
module test_pin_debounce_filter;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ADDR = 8'hDF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] pins_raw = 8'h00;
  logic       sample_stb = 1'b0;
  logic       stop_mode = 1'b0;
  logic [7:0] pins_filt;

  int checks = 0;
  int errors = 0;
  int stb_per = 1;
  int stb_ph = 0;
  int ncyc = 0;
  int t0 = 0;
  int hi_cnt [8];
  int first_hi [8];

  pin_debounce_filter i_pin_debounce_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .pins_raw   (pins_raw),
    .sample_stb (sample_stb),
    .stop_mode  (stop_mode),
    .pins_filt  (pins_filt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Strobe generator: high one cycle in every stb_per cycles.
  always @(posedge clk) begin
    stb_ph     <= (stb_ph >= stb_per - 1) ? 0 : stb_ph + 1;
    sample_stb <= (stb_per == 1) || (stb_ph == 0);
  end

  // Output monitor on falling edges.
  always @(negedge clk) begin
    ncyc = ncyc + 1;
    for (int c = 0; c < 8; c++) begin
      if (pins_filt[c]) begin
        hi_cnt[c] = hi_cnt[c] + 1;
        if (first_hi[c] < 0) first_hi[c] = ncyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    for (int c = 0; c < 8; c++) begin
      hi_cnt[c]   = 0;
      first_hi[c] = -1;
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    step(1);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Apply a raw pulse of len cycles on the pins in mask, then let it settle.
  task automatic pulse(input logic [7:0] mask, input int len);
    clear_mon();
    t0 = ncyc;
    pins_raw = mask;
    step(len);
    pins_raw = 8'h00;
    step(24);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    clear_mon();
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1: reset state
    rd(ADDR, rv);
    chk(rv == 8'h00, "R1 enable reset value", rv, 0);
    chk(pins_filt == 8'h00, "R1 outputs after reset", pins_filt, 0);

    // R2: register sweep over every value
    for (int v = 0; v < 256; v++) begin
      wr(ADDR, 8'(v));
      rd(ADDR, rv);
      chk(rv == 8'(v), "R2 readback", rv, v);
    end
    wr(ADDR, 8'hA5);
    wr(8'hDE, 8'h3C);
    rd(ADDR, rv);
    chk(rv == 8'hA5, "R2 foreign write ignored", rv, 8'hA5);
    rd(8'hDE, rv);
    chk(rv == 8'h00, "R2 foreign read zero", rv, 0);

    // R4: disabled channels, pulses of several lengths on all pins
    wr(ADDR, 8'h00);
    for (int len = 1; len <= 4; len++) begin
      pulse(8'hFF, len);
      for (int c = 0; c < 8; c++) begin
        chk(hi_cnt[c] == len, "R4 pass length", hi_cnt[c], len);
        chk(first_hi[c] == t0 + 3, "R4 pass latency", first_hi[c] - t0, 3);
      end
    end

    // R5/R6: enabled, strobe each cycle, pulse each channel alone
    wr(ADDR, 8'hFF);
    for (int ch = 0; ch < 8; ch++) begin
      for (int len = 1; len <= 6; len++) begin
        pulse(8'(1 << ch), len);
        for (int c = 0; c < 8; c++) begin
          int exp_hi;
          exp_hi = (c == ch && len >= 3) ? len : 0;
          chk(hi_cnt[c] == exp_hi, "R6 filtered length", hi_cnt[c], exp_hi);
        end
        if (len >= 3)
          chk(first_hi[ch] == t0 + 6, "R5 filter latency", first_hi[ch] - t0, 6);
      end
    end

    // R3: one channel disabled at a time, all pins pulsed one cycle
    for (int ch = 0; ch < 8; ch++) begin
      wr(ADDR, ~8'(1 << ch));
      pulse(8'hFF, 1);
      for (int c = 0; c < 8; c++) begin
        int exp_hi;
        exp_hi = (c == ch) ? 1 : 0;
        chk(hi_cnt[c] == exp_hi, "R3 bit to channel map", hi_cnt[c], exp_hi);
      end
    end

    // R7: strobe every 4 cycles
    wr(ADDR, 8'hFF);
    stb_per = 4;
    step(2);
    pulse(8'hFF, 7);
    chk(hi_cnt[0] == 0 && hi_cnt[7] == 0, "R7 7-cycle pulse", hi_cnt[0], 0);
    pulse(8'hFF, 8);
    chk(hi_cnt[3] == 0 && hi_cnt[4] == 0, "R7 8-cycle pulse", hi_cnt[3], 0);
    pulse(8'hFF, 12);
    chk(hi_cnt[1] == 12 && hi_cnt[6] == 12, "R7 12-cycle pulse", hi_cnt[1], 12);
    pulse(8'hFF, 16);
    chk(hi_cnt[2] == 16 && hi_cnt[5] == 16, "R7 16-cycle pulse", hi_cnt[2], 16);
    stb_per = 1;
    step(2);

    // R8: stop mode bypasses filtering
    stop_mode = 1'b1;
    step(1);
    pulse(8'hFF, 1);
    for (int c = 0; c < 8; c++) begin
      chk(hi_cnt[c] == 1, "R8 stop bypass length", hi_cnt[c], 1);
      chk(first_hi[c] == t0 + 3, "R8 stop bypass latency", first_hi[c] - t0, 3);
    end

    // R9: release stop, filtering resumes without a write
    stop_mode = 1'b0;
    step(1);
    pulse(8'hFF, 1);
    for (int c = 0; c < 8; c++)
      chk(hi_cnt[c] == 0, "R9 filter restored", hi_cnt[c], 0);
    pulse(8'hFF, 3);
    chk(hi_cnt[0] == 3, "R9 valid pulse after stop", hi_cnt[0], 3);

    // R10: enabling with pin held high creates no edge
    wr(ADDR, 8'h00);
    pins_raw = 8'hFF;
    step(6);
    clear_mon();
    wr(ADDR, 8'hFF);
    step(9);
    for (int c = 0; c < 8; c++)
      chk(hi_cnt[c] == 10, "R10 enable keeps level", hi_cnt[c], 10);

    // R10: stop release after pin fell during stop creates no edge
    stop_mode = 1'b1;
    step(1);
    pins_raw = 8'h00;
    step(6);
    chk(pins_filt == 8'h00, "R8 stop follows pin", pins_filt, 0);
    clear_mon();
    stop_mode = 1'b0;
    step(10);
    for (int c = 0; c < 8; c++)
      chk(hi_cnt[c] == 0, "R10 stop release keeps level", hi_cnt[c], 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule